// File: doc/BRIEF.md
# Stereo Zero-Data Detector

This block watches a two-channel stream of 24-bit two's-complement PCM samples. Samples arrive with a one-cycle frame strobe. The block raises a single flag once both the left and the right sample have been exactly zero for 8192 consecutive frames. The flag is used downstream to decide that a source has gone silent, for example to gate an external mute or to let analog stages idle. It drops at once on the first frame that carries any nonzero sample, on either channel.

A run counter advances by one on each strobed frame in which both samples are zero. It stops at its terminal value and restarts from zero on any nonzero frame. A synchronous power-down input and the asynchronous chip reset both hold the flag low and clear the count. After either one ends, a full qualification window is needed again. The window length and the sample width are parameters.

Top module: `zdet_stereo`

## Requirements
- R1: With `zero_flag` low, after 8192 consecutive strobed frames in which both samples equal 24'h000000, `zero_flag` is high after the clock edge that captures the 8192nd such frame, and not after the edge that captures the 8191st.
- R2: A strobed frame in which either sample is nonzero drives `zero_flag` low at the clock edge that captures it and restarts the run, so a further 8192 all-zero frames are needed before the flag rises again.
- R3: While `pwr_dn` is high at a clock edge, `zero_flag` is low after that edge and the run is cleared. After `pwr_dn` returns low, the flag rises only on the 8192nd all-zero frame.
- R4: `rst_n` low forces `zero_flag` low without waiting for a clock edge. Internal reset is released on the second rising clock edge after `rst_n` rises, and the flag cannot rise before 8192 all-zero frames have been captured after that.
- R5: On cycles with `frame_vld` low, the sample inputs are ignored: neither the run count nor `zero_flag` changes, whatever values the samples hold.
- R6: The zero test covers the whole word on each channel. A sample of 24'h000001 or of 24'h800000 on either channel is treated as nonzero.
- R7: Once high, `zero_flag` stays high for any number of further all-zero frames. The run count saturates at 8192 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_dn | input | 1 | Synchronous power-down hold; clears the run and the flag |
| frame_vld | input | 1 | One-cycle strobe marking a captured stereo frame |
| smp_left | input | 24 | Left-channel sample, two's complement |
| smp_right | input | 24 | Right-channel sample, two's complement |
| zero_flag | output | 1 | High after a full run of all-zero frames |

## Verification
The embedded properties are checked on every cycle:
- the flag is high only while the run count sits at its terminal value;
- a strobed nonzero frame or power-down leaves the flag low on the next cycle;
- the count never passes its limit and steps by exactly one on an all-zero frame;
- non-strobe cycles change nothing.

Only the bench's scenarios show the following:
- the exact frame on which the flag rises after reset, after power-down and after a nonzero frame;
- that single-bit values at each end of the word count as nonzero;
- that the asynchronous reset drops the flag between clock edges.

// File: rtl/zdet_pkg.sv
package zdet_pkg;

  // Default sample width of one PCM channel.
  localparam int unsigned ZDET_SAMPLE_W = 24;

  // Default qualification window in frames.
  localparam int unsigned ZDET_RUN_FRAMES = 8192;

  // Number of channels watched together.
  localparam int unsigned ZDET_NUM_CH = 2;

  // Channel index names used by the generate loop.
  typedef enum logic {
    ZCH_LEFT  = 1'b0,
    ZCH_RIGHT = 1'b1
  } zdet_ch_e;

endpackage

// File: rtl/zdet_rst_sync.sv
module zdet_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/zdet_chan_zero.sv
module zdet_chan_zero #(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic [SAMPLE_W-1:0] sample,
  output logic                is_zero
);

  // Whole-word test: every bit, including sign and LSB, must be clear (R6).
  always_comb begin
    is_zero = (sample == '0);
  end

endmodule

// File: rtl/zdet_run_counter.sv
module zdet_run_counter #(
  parameter int unsigned RUN_FRAMES = 8192,
  parameter int unsigned CNT_W      = $clog2(RUN_FRAMES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_clr,
  input  logic             strobe,
  input  logic             all_zero,
  output logic [CNT_W-1:0] run_cnt,
  output logic             run_last
);

  localparam logic [CNT_W-1:0] RUN_LIM  = CNT_W'(RUN_FRAMES);
  localparam logic [CNT_W-1:0] RUN_PRE  = CNT_W'(RUN_FRAMES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Clock enable: a strobe or a power-down hold updates the counter.
  always_comb begin
    cnt_en = strobe | hold_clr;
    cnt_d  = cnt_q;
    if (hold_clr) begin
      cnt_d = '0;
    end else if (strobe) begin
      if (!all_zero) begin
        cnt_d = '0;
      end else if (cnt_q != RUN_LIM) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign run_cnt  = cnt_q;
  // High when the next all-zero frame completes (or keeps) a full run.
  assign run_last = (cnt_q >= RUN_PRE);

  p_count_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= RUN_LIM);

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && all_zero && !hold_clr && (cnt_q != RUN_LIM))
      |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_count_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !all_zero) |=> (cnt_q == '0));

  p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_clr |=> (cnt_q == '0));

  p_count_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !hold_clr) |=> $stable(cnt_q));

endmodule

// File: rtl/zdet_stereo.sv
module zdet_stereo
  import zdet_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = ZDET_SAMPLE_W,
  parameter int unsigned RUN_FRAMES = ZDET_RUN_FRAMES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwr_dn,
  input  logic                frame_vld,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  output logic                zero_flag
);

  localparam int unsigned CNT_W = $clog2(RUN_FRAMES + 1);
  localparam logic [CNT_W-1:0] RUN_LIM = CNT_W'(RUN_FRAMES);

  logic                                   rst_sync_n;
  logic [ZDET_NUM_CH-1:0][SAMPLE_W-1:0]   ch_smp;
  logic [ZDET_NUM_CH-1:0]                 ch_zero;
  logic                                   both_zero;
  logic [CNT_W-1:0]                       run_cnt;
  logic                                   run_last;
  logic                                   flag_q;
  logic                                   flag_d;
  logic                                   flag_en;

  zdet_rst_sync #(
    .STAGES(2)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  assign ch_smp[ZCH_LEFT]  = smp_left;
  assign ch_smp[ZCH_RIGHT] = smp_right;

  for (genvar gi = 0; gi < ZDET_NUM_CH; gi++) begin : g_chan
    zdet_chan_zero #(
      .SAMPLE_W(SAMPLE_W)
    ) u_chan_zero (
      .sample (ch_smp[gi]),
      .is_zero(ch_zero[gi])
    );
  end

  assign both_zero = &ch_zero;

  zdet_run_counter #(
    .RUN_FRAMES(RUN_FRAMES),
    .CNT_W     (CNT_W)
  ) u_run_counter (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .hold_clr(pwr_dn),
    .strobe  (frame_vld),
    .all_zero(both_zero),
    .run_cnt (run_cnt),
    .run_last(run_last)
  );

  // Flag next state: set on the frame that completes the run, cleared by
  // any nonzero frame or by power-down, held otherwise.
  always_comb begin
    flag_en = frame_vld | pwr_dn;
    flag_d  = flag_q;
    if (pwr_dn) begin
      flag_d = 1'b0;
    end else if (frame_vld) begin
      flag_d = both_zero & run_last;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign zero_flag = flag_q;

  p_flag_full_run_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    zero_flag |-> (run_cnt == RUN_LIM));

  p_nonzero_drops_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (frame_vld && ((smp_left != '0) || (smp_right != '0))) |=> !zero_flag);

  p_pwrdn_low_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pwr_dn |=> !zero_flag);

  p_idle_stable_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!frame_vld && !pwr_dn) |=> $stable(zero_flag));

  p_flag_sticks_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (zero_flag && frame_vld && !pwr_dn && (smp_left == '0) && (smp_right == '0))
      |=> zero_flag);

endmodule

// File: tb/zdet_stereo_bench.sv
module zdet_stereo_bench;

  localparam int unsigned W   = 24;
  localparam int unsigned RUN = 8192;

  logic         clk;
  logic         rst_n;
  logic         pwr_dn;
  logic         frame_vld;
  logic [W-1:0] smp_left;
  logic [W-1:0] smp_right;
  logic         zero_flag;

  int checks;
  int errors;
  bit done;

  zdet_stereo u_zdet_stereo (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_dn   (pwr_dn),
    .frame_vld(frame_vld),
    .smp_left (smp_left),
    .smp_right(smp_right),
    .zero_flag(zero_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: zero_flag=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive n back-to-back strobed frames, inputs changed at negedges.
  task automatic frames(input int n, input logic [W-1:0] l, input logic [W-1:0] r);
    @(negedge clk);
    smp_left  = l;
    smp_right = r;
    frame_vld = 1'b1;
    repeat (n) @(negedge clk);
    frame_vld = 1'b0;
    smp_left  = '0;
    smp_right = '0;
  endtask

  task automatic qualify(input string req);
    frames(RUN - 1, '0, '0);
    check(req, zero_flag, 1'b0);
    frames(1, '0, '0);
    check(req, zero_flag, 1'b1);
  endtask

  task automatic t_reset_state;
    check("R4 reset", zero_flag, 1'b0);
  endtask

  task automatic t_first_run;
    qualify("R1");
    frames(300, '0, '0);
    check("R7 saturate", zero_flag, 1'b1);
  endtask

  task automatic t_idle_ignored;
    @(negedge clk);
    smp_left  = 24'h123456;
    smp_right = 24'h800000;
    repeat (10) @(negedge clk);
    check("R5 idle nonzero", zero_flag, 1'b1);
    smp_left  = '0;
    smp_right = '0;
    frames(1, '0, '0);
    check("R5 run kept", zero_flag, 1'b1);
  endtask

  task automatic t_nonzero_left;
    frames(1, 24'h000001, '0);
    check("R2 drop", zero_flag, 1'b0);
    frames(100, '0, '0);
    // Idle cycles with nonzero data in the middle of a partial run.
    @(negedge clk);
    smp_right = 24'hFFFFFF;
    repeat (5) @(negedge clk);
    smp_right = '0;
    frames(RUN - 101, '0, '0);
    check("R5 gap in run", zero_flag, 1'b0);
    frames(1, '0, '0);
    check("R2 requalify", zero_flag, 1'b1);
  endtask

  task automatic t_msb_right;
    frames(1, '0, 24'h800000);
    check("R6 right msb", zero_flag, 1'b0);
    qualify("R6 after msb");
    frames(1, 24'h800000, '0);
    check("R6 left msb", zero_flag, 1'b0);
    frames(1, '0, 24'h000001);
    check("R6 right lsb", zero_flag, 1'b0);
    qualify("R2 after lsb");
  endtask

  task automatic t_power_down;
    @(negedge clk);
    pwr_dn = 1'b1;
    @(negedge clk);
    check("R3 pwr_dn", zero_flag, 1'b0);
    frames(20, '0, '0);
    check("R3 held", zero_flag, 1'b0);
    pwr_dn = 1'b0;
    qualify("R3 restart");
  endtask

  task automatic t_async_reset;
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    check("R4 async", zero_flag, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 released", zero_flag, 1'b0);
    qualify("R4 restart");
  endtask

  initial begin
    checks    = 0;
    errors    = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    pwr_dn    = 1'b0;
    frame_vld = 1'b0;
    smp_left  = '0;
    smp_right = '0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_first_run();
    t_idle_ignored();
    t_nonzero_left();
    t_msb_right();
    t_power_down();
    t_async_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule